// File: doc/BRIEF.md
# Control-Word Register Datapath

This block is a small execution datapath built around seven general registers and a combinational ALU. Every clock it carries out exactly one micro-operation described by a 14-bit control word. The word names a source for each of the two operand buses, an ALU function and a destination register. The ALU result always appears on the data output. When the destination field names a register, that register captures the result on the next rising clock edge.

The block holds no sequencing of its own. Whatever sits above it (a microsequencer, a hardwired decoder or a test harness) presents one control word per cycle. A source code of zero takes the external data input instead of a register. A destination code of zero performs the operation without storing it. With both codes at zero the block acts as a pass-through or transform path from the input to the output.

Data width is a parameter with a default of 8 bits. There is no state machine in this block: the only state is the register file, which asynchronous active-low reset clears.

Top module: `rdp_datapath`

## Requirements
- R1: While `rst_n` is low and after it is released, every register R1..R7 reads as zero until it is written.
- R2: The control word is laid out as bits [13:11] source A, [10:8] source B, [7:5] destination, [4:0] ALU function.
- R3: A source code of 000 places `data_in` on that operand bus, and codes 001..111 place R1..R7 there.
- R4: A destination code of 000 leaves every register unchanged. Codes 001..111 write the ALU result into R1..R7 on the rising clock edge.
- R5: `data_out` always equals the ALU result for the current control word and operands, whether or not a register is written.
- R6: The arithmetic functions are 00000 pass A, 00001 A+1, 00010 A+B, 00101 A-B and 00110 A-1, all taken modulo 2^WIDTH.
- R7: The bitwise functions are 01000 A AND B, 01010 A OR B, 01100 A XOR B and 01110 NOT A. Choosing one register as both sources and as the destination with 01100 clears that register.
- R8: Function 10000 shifts A right by one and 11000 shifts A left by one. Both are logical shifts that fill the vacated bit with zero.
- R9: Any function code not listed in R6 to R8 yields a zero result.
- R10: Both operands are read from the register values held before the clock edge, so a register that is both read and written changes exactly once per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; registers write on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; clears R1..R7 |
| ctrl_word | input | 14 | Micro-operation: source A, source B, destination, function |
| data_in | input | WIDTH | External operand, chosen by source code 000 |
| data_out | output | WIDTH | ALU result for the current control word |

## Verification
The assertions assume that `ctrl_word` and `data_in` are known and held steady across each rising edge. They also assume that reset is applied before the first edge. Several properties compare the output in one cycle with the output in the next, so they rely on register contents changing only through the destination field. The stimulus meets these assumptions: it changes inputs only on the falling edge, holds reset over the first cycles, and walks every pair of source codes against all 32 function codes. It then reads back every register through the pass function to confirm what was or was not written.

// File: rtl/rdp_pkg.sv
package rdp_pkg;

    // Field widths of the micro-operation word
    localparam int SEL_W  = 3;
    localparam int FUNC_W = 5;
    localparam int CTRL_W = 3 * SEL_W + FUNC_W;

    // Field positions (a driving sequencer depends on these)
    localparam int SRCA_LSB = 2 * SEL_W + FUNC_W;
    localparam int SRCB_LSB = SEL_W + FUNC_W;
    localparam int DST_LSB  = FUNC_W;

    typedef enum logic [FUNC_W-1:0] {
        FN_PASS = 5'b00000,
        FN_INC  = 5'b00001,
        FN_ADD  = 5'b00010,
        FN_SUB  = 5'b00101,
        FN_DEC  = 5'b00110,
        FN_AND  = 5'b01000,
        FN_OR   = 5'b01010,
        FN_XOR  = 5'b01100,
        FN_NOT  = 5'b01110,
        FN_SHR  = 5'b10000,
        FN_SHL  = 5'b11000
    } func_t;

    typedef struct packed {
        logic [SEL_W-1:0]  src_a;
        logic [SEL_W-1:0]  src_b;
        logic [SEL_W-1:0]  dst;
        logic [FUNC_W-1:0] func;
    } uop_t;

endpackage

// File: rtl/rdp_regfile.sv
module rdp_regfile
    import rdp_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [SEL_W-1:0] rd_sel_a,
    input  logic [SEL_W-1:0] rd_sel_b,
    output logic [WIDTH-1:0] rd_data_a,
    output logic [WIDTH-1:0] rd_data_b
);
    // Code zero is reserved (external input / no write)
    localparam int NUM_REGS = (1 << SEL_W) - 1;

    logic [WIDTH-1:0] regs_q [1:NUM_REGS];

    // R4: one storage word per nonzero destination code
    for (genvar k = 1; k <= NUM_REGS; k++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs_q[k] <= '0;
            end else if (wr_sel == SEL_W'(k)) begin
                regs_q[k] <= wr_data;
            end
        end
    end

    // Combinational reads of pre-edge contents (R10)
    always_comb begin
        rd_data_a = '0;
        rd_data_b = '0;
        for (int i = 1; i <= NUM_REGS; i++) begin
            if (rd_sel_a == SEL_W'(i)) rd_data_a = regs_q[i];
            if (rd_sel_b == SEL_W'(i)) rd_data_b = regs_q[i];
        end
    end

endmodule

// File: rtl/rdp_operand_sel.sv
module rdp_operand_sel
    import rdp_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [SEL_W-1:0] sel,
    input  logic [WIDTH-1:0] ext_data,
    input  logic [WIDTH-1:0] reg_data,
    output logic [WIDTH-1:0] bus
);
    // R3: code zero steers the external input onto the bus
    always_comb begin
        if (sel == '0) bus = ext_data;
        else           bus = reg_data;
    end

endmodule

// File: rtl/rdp_alu.sv
module rdp_alu
    import rdp_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [FUNC_W-1:0] func,
    input  logic [WIDTH-1:0]  opa,
    input  logic [WIDTH-1:0]  opb,
    output logic [WIDTH-1:0]  result
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    func_t fn;
    assign fn = func_t'(func);

    always_comb begin
        unique case (fn)
            FN_PASS: result = opa;                        // R6
            FN_INC:  result = opa + ONE;                  // R6
            FN_ADD:  result = opa + opb;                  // R6
            FN_SUB:  result = opa - opb;                  // R6
            FN_DEC:  result = opa - ONE;                  // R6
            FN_AND:  result = opa & opb;                  // R7
            FN_OR:   result = opa | opb;                  // R7
            FN_XOR:  result = opa ^ opb;                  // R7
            FN_NOT:  result = ~opa;                       // R7
            FN_SHR:  result = {1'b0, opa[WIDTH-1:1]};     // R8
            FN_SHL:  result = {opa[WIDTH-2:0], 1'b0};     // R8
            default: result = '0;                         // R9
        endcase
    end

endmodule

// File: rtl/rdp_datapath.sv
module rdp_datapath
    import rdp_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CTRL_W-1:0] ctrl_word,
    input  logic [WIDTH-1:0]  data_in,
    output logic [WIDTH-1:0]  data_out
);
    uop_t             uop;
    logic [WIDTH-1:0] reg_a;
    logic [WIDTH-1:0] reg_b;
    logic [WIDTH-1:0] bus_a;
    logic [WIDTH-1:0] bus_b;
    logic [WIDTH-1:0] alu_y;

    // R2: fixed field layout
    assign uop = uop_t'(ctrl_word);

    rdp_regfile #(.WIDTH(WIDTH)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_sel    (uop.dst),
        .wr_data   (alu_y),
        .rd_sel_a  (uop.src_a),
        .rd_sel_b  (uop.src_b),
        .rd_data_a (reg_a),
        .rd_data_b (reg_b)
    );

    rdp_operand_sel #(.WIDTH(WIDTH)) u_sel_a (
        .sel      (uop.src_a),
        .ext_data (data_in),
        .reg_data (reg_a),
        .bus      (bus_a)
    );

    rdp_operand_sel #(.WIDTH(WIDTH)) u_sel_b (
        .sel      (uop.src_b),
        .ext_data (data_in),
        .reg_data (reg_b),
        .bus      (bus_b)
    );

    rdp_alu #(.WIDTH(WIDTH)) u_alu (
        .func   (uop.func),
        .opa    (bus_a),
        .opb    (bus_b),
        .result (alu_y)
    );

    // R5: result is always visible
    assign data_out = alu_y;

endmodule

// File: rtl/rdp_datapath_chk.sv
module rdp_datapath_chk
    import rdp_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CTRL_W-1:0] ctrl_word,
    input logic [WIDTH-1:0]  data_in,
    input logic [WIDTH-1:0]  data_out
);
    logic [SEL_W-1:0]  sa;
    logic [SEL_W-1:0]  dd;
    logic [FUNC_W-1:0] fc;
    logic              listed;

    assign sa = ctrl_word[SRCA_LSB +: SEL_W];
    assign dd = ctrl_word[DST_LSB +: SEL_W];
    assign fc = ctrl_word[FUNC_W-1:0];

    always_comb begin
        case (fc)
            5'b00000, 5'b00001, 5'b00010, 5'b00101, 5'b00110,
            5'b01000, 5'b01010, 5'b01100, 5'b01110,
            5'b10000, 5'b11000: listed = 1'b1;
            default:            listed = 1'b0;
        endcase
    end

    // R9
    unlisted_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !listed |-> data_out == '0);

    // R3
    ext_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sa == '0 && fc == 5'b00000) |-> data_out == data_in);

    // R7
    ext_invert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sa == '0 && fc == 5'b01110) |-> data_out == ~data_in);

    // R8
    ext_shl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sa == '0 && fc == 5'b11000) |-> data_out == (data_in << 1));

    // R4
    no_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dd == '0 && sa != '0 && fc == 5'b00000)
        |=> ((ctrl_word == $past(ctrl_word)) -> data_out == $past(data_out)));

    // R10
    write_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dd != '0)
        |=> ((sa == $past(dd) && fc == 5'b00000) -> data_out == $past(data_out)));

endmodule

bind rdp_datapath rdp_datapath_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_word (ctrl_word),
    .data_in   (data_in),
    .data_out  (data_out)
);

// File: tb/rdp_datapath_test.sv
`timescale 1ns/1ps
module rdp_datapath_test;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [13:0]  ctrl_word = '0;
    logic [W-1:0] data_in = '0;
    logic [W-1:0] data_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [W-1:0] mdl [0:7];
    logic [W-1:0] pre [0:7];

    always #2 clk = ~clk;

    rdp_datapath #(.WIDTH(W)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_word (ctrl_word),
        .data_in   (data_in),
        .data_out  (data_out)
    );

    function automatic logic [13:0] mk(int a, int b, int d, int f);
        return {3'(a), 3'(b), 3'(d), 5'(f)};
    endfunction

    function automatic logic [W-1:0] expect_of(int f, logic [W-1:0] a, logic [W-1:0] b);
        int unsigned ua = a;
        int unsigned ub = b;
        case (f)
            0:  return W'(ua);
            1:  return W'(ua + 1);
            2:  return W'(ua + ub);
            5:  return W'(ua + 256 - ub);
            6:  return W'(ua + 255);
            8:  return a & b;
            10: return a | b;
            12: return a ^ b;
            14: return W'(255 - ua);
            16: return W'(ua / 2);
            24: return W'(ua * 2);
            default: return '0;
        endcase
    endfunction

    function automatic string tag_of(int a, int b, int f);
        if (a == 0 || b == 0) return "R3";
        case (f)
            0, 1, 2, 5, 6:  return "R6";
            8, 10, 12, 14:  return "R7";
            16, 24:         return "R8";
            default:        return "R9";
        endcase
    endfunction

    task automatic check(string tag, logic [W-1:0] got, logic [W-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // Apply one micro-operation, check the output, then update the model
    task automatic step(logic [13:0] cw, logic [W-1:0] ext, string tag);
        int sa = int'(cw[13:11]);
        int sb = int'(cw[10:8]);
        int sd = int'(cw[7:5]);
        int fn = int'(cw[4:0]);
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic [W-1:0] e;
        @(negedge clk);
        ctrl_word = cw;
        data_in   = ext;
        #1;
        a = (sa == 0) ? ext : mdl[sa];
        b = (sb == 0) ? ext : mdl[sb];
        e = expect_of(fn, a, b);
        check(tag, data_out, e);
        @(posedge clk);
        if (sd != 0) mdl[sd] = e;
    endtask

    initial begin
        for (int k = 0; k < 8; k++) mdl[k] = '0;
        pre[0] = 8'h00; pre[1] = 8'h81; pre[2] = 8'h7F; pre[3] = 8'hFF;
        pre[4] = 8'h01; pre[5] = 8'h55; pre[6] = 8'hAA; pre[7] = 8'h80;

        // R1: registers read zero during reset and after release
        @(negedge clk);
        ctrl_word = mk(3, 0, 0, 0);
        data_in = 8'h3C;
        #1 check("R1", data_out, 8'h00);
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int k = 1; k < 8; k++) step(mk(k, 0, 0, 0), 8'h3C, "R1");

        // R4: load each register from the input, then read back
        for (int k = 1; k < 8; k++) step(mk(0, 0, k, 0), pre[k], "R4");
        for (int k = 1; k < 8; k++) step(mk(k, 0, 0, 0), 8'h00, "R4");

        // Sweep all source pairs against every function code, no write (R5)
        for (int a = 0; a < 8; a++)
            for (int b = 0; b < 8; b++)
                for (int f = 0; f < 32; f++)
                    step(mk(a, b, 0, f), W'(a * 37 + b * 11 + f * 5 + 3),
                         tag_of(a, b, f));

        // R4: destination code zero left every register intact
        for (int k = 1; k < 8; k++) step(mk(k, 0, 0, 0), 8'hEE, "R4");

        // R5: output tracks a new input without any write
        step(mk(0, 0, 0, 0), 8'h5A, "R5");
        step(mk(0, 0, 0, 0), 8'hA5, "R5");

        // R2: distinct fields, R2 - R3 into R6, then read R6
        step(mk(2, 3, 6, 5), 8'h00, "R2");
        step(mk(6, 0, 0, 0), 8'h00, "R2");

        // R10: read-modify-write on one register each cycle
        for (int i = 0; i < 3; i++) step(mk(1, 1, 1, 1), 8'h00, "R10");
        step(mk(1, 0, 0, 0), 8'h00, "R10");
        step(mk(4, 4, 4, 2), 8'h00, "R10");
        step(mk(4, 0, 0, 0), 8'h00, "R10");

        // R7: clear by XOR of a register with itself
        step(mk(5, 5, 5, 12), 8'h00, "R7");
        step(mk(5, 0, 0, 0), 8'h00, "R7");

        // R6 / R8 boundaries
        step(mk(0, 0, 0, 1), 8'hFF, "R6");
        step(mk(0, 0, 0, 6), 8'h00, "R6");
        step(mk(0, 0, 0, 24), 8'h80, "R8");
        step(mk(0, 0, 0, 16), 8'h01, "R8");
        step(mk(0, 0, 0, 16), 8'hFF, "R8");
        step(mk(0, 0, 0, 24), 8'hFF, "R8");

        // R9: unlisted codes with nonzero operands
        step(mk(3, 3, 0, 31), 8'hFF, "R9");
        step(mk(0, 0, 0, 3), 8'hFF, "R9");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog got=hung exp=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule